// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Bank

This block is the software-visible configuration store of a two-chip-select SDRAM controller. A 32-bit bus slave reaches a small set of global registers (system configuration, chip-select configuration, sharing, delay-line A control, power) and one set of registers per chip select (memory configuration, mode, extended mode 2, two AC timing words, refresh control, manual command). The block writes each register through its own keep-mask. It applies write locks and answers with a computed delay-line status. It flags every access it cannot honour on a one-cycle error strobe, and it latches the address of that access.

The chip-select banks repeat at a stride of 0x30 from offset 0x80. Inside the bank window, the timing words of chip select 1 occupy the slots that hold inert delay-line registers in bank 0. The slots that carry the chip-select-0 timing words are not decoded in bank 1. The block drives no memory pins and issues no commands. It only holds and reports configuration.

Top module: `sdram_cfg_regs`

## Requirements
- R1: After a synchronous reset the power register (0x70) reads 0x85 and both mode registers (0x84, 0xB4) read 0x24. Every other stored register reads 0, and both lock bits are clear.
- R2: Access size is encoded 0 byte, 1 halfword, 2 word, 3 reserved. Only size 2 is accepted. Any other size reads 0, raises the error strobe in the next cycle and leaves all registers unchanged.
- R3: Offset 0x14 reads 1 and offset 0x00 reads the REVISION parameter. Offsets 0x48 and 0x4C read 0. A write to 0x00, 0x14, 0x48, 0x4C, 0x64 or 0x6C raises the error strobe and changes nothing.
- R4: A write to 0x10 keeps bits 4:3, to 0x40 keeps mask 0x30F, to 0x60 keeps mask 0xFFFF00FE, and to 0x70 keeps mask 0x04FFFFFD.
- R5: The sharing register at 0x44 stores the write ANDed with 0x40007F00 while its bit 30 is 0. Once bit 30 is 1, writes leave it unchanged until reset.
- R6: 0x64 reads the bitwise inverse of (0x60 AND 0x4). 0x68 and 0x6C read 0, and a write to 0x68 is dropped without an error.
- R7: Offsets 0x80..0xA8 reach chip select 0 and offsets 0xB0..0xD8 reach chip select 1 at the same in-bank offset. The two banks hold independent values.
- R8: Memory configuration (in-bank 0x00) accepts writes only while its bit 30 is 0. The keep-mask is 0x477BFFDF when bit 19 of the written value is 1, and 0x41FBFFDF otherwise.
- R9: Mode (in-bank 0x04) and extended mode 2 (0x0C) keep 0xFFF. Refresh control (0x24) keeps 0x00FFFF03, and manual command (0x28) keeps 0xFFFF000F.
- R10: Timing A keeps mask 0xFFFFFFDF and timing B keeps mask 0x000377FF. For chip select 0 they sit at 0x9C/0xA0, and for chip select 1 at 0xC4/0xC8. 0x94/0x98 read 0 and drop writes without an error.
- R11: Any other offset, including 0xCC, 0xD0 and any address with nonzero bits 1:0, reads 0 and raises the error strobe for one cycle. The error address output then holds the address exactly as presented.
- R12: The error strobe is high only in the cycle after an access that R2, R3 or R11 names. A legal access never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_size | input | 2 | Access size code (2 = word) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from stored state |
| err_pulse | output | 1 | One-cycle error strobe, registered |
| err_addr | output | ADDR_W | Address of the last flagged access |

## Verification
Two things can coincide on the same access: a keep-mask and a lock or overlay rule both decide the stored value. One case is a write of all ones, which sets a lock bit and picks the bit-19 memory-configuration mask in the same cycle. Another is a write to a bank-1 timing slot, which must not reach the bank-0 delay-line slot at the same in-bank offset. The bench writes several patterns to every word offset in turn and reads the whole map back after each pass. It judges each value against masks, locks and reset values computed arithmetically from the requirements, and after every access it checks the error strobe and the error address.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

  localparam int DATA_W = 32;
  localparam int NCS    = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [4:0] {
    SEL_NONE,
    SEL_REV,
    SEL_SYSCFG,
    SEL_STATUS,
    SEL_CSCFG,
    SEL_SHARE,
    SEL_ZERO,
    SEL_DLLA,
    SEL_DLLA_ST,
    SEL_POWER,
    SEL_MCFG,
    SEL_MODE,
    SEL_EMODE2,
    SEL_TIMA,
    SEL_TIMB,
    SEL_RFR,
    SEL_MANUAL
  } regsel_e;

  typedef struct packed {
    regsel_e sel;
    logic    cs;
    logic    rd_err;
    logic    wr_err;
  } dec_t;

  // keep-masks
  localparam logic [DATA_W-1:0] M_SYSCFG  = 32'h0000_0018;
  localparam logic [DATA_W-1:0] M_CSCFG   = 32'h0000_030F;
  localparam logic [DATA_W-1:0] M_SHARE   = 32'h4000_7F00;
  localparam logic [DATA_W-1:0] M_DLLA    = 32'hFFFF_00FE;
  localparam logic [DATA_W-1:0] M_POWER   = 32'h04FF_FFFD;
  localparam logic [DATA_W-1:0] M_MCFG_LG = 32'h477B_FFDF;
  localparam logic [DATA_W-1:0] M_MCFG_NM = 32'h41FB_FFDF;
  localparam logic [DATA_W-1:0] M_MODE    = 32'h0000_0FFF;
  localparam logic [DATA_W-1:0] M_RFR     = 32'h00FF_FF03;
  localparam logic [DATA_W-1:0] M_MANUAL  = 32'hFFFF_000F;
  localparam logic [DATA_W-1:0] M_TIMA    = 32'hFFFF_FFDF;
  localparam logic [DATA_W-1:0] M_TIMB    = 32'h0003_77FF;

  localparam logic [DATA_W-1:0] RST_POWER = 32'h0000_0085;
  localparam logic [DATA_W-1:0] RST_MODE  = 32'h0000_0024;

  localparam int LOCK_BIT   = 30;
  localparam int MUXSEL_BIT = 19;
  localparam int DLL_PROBE  = 2;

endpackage

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode
  import sdram_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int unsigned CS_BASE   = 32'h80,
  parameter int unsigned CS_STRIDE = 32'h30
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int unsigned BANK_TOP = 32'h28;

  logic [31:0] a32;
  logic [31:0] off0;
  logic [31:0] off1;
  logic        in0;
  logic        in1;
  logic [31:0] off;
  logic        cs;

  assign a32  = 32'(addr);
  assign off0 = a32 - CS_BASE;
  assign off1 = a32 - (CS_BASE + CS_STRIDE);
  assign in0  = (a32 >= CS_BASE) && (off0 <= BANK_TOP);
  assign in1  = (a32 >= CS_BASE + CS_STRIDE) && (off1 <= BANK_TOP);
  assign cs   = in1;
  assign off  = in1 ? off1 : off0;

  always_comb begin
    dec = '{sel: SEL_NONE, cs: 1'b0, rd_err: 1'b1, wr_err: 1'b1};
    if (a32[1:0] == 2'b00) begin
      if (in0 || in1) begin
        dec.cs     = cs;
        dec.rd_err = 1'b0;
        dec.wr_err = 1'b0;
        case (off)
          32'h00: dec.sel = SEL_MCFG;
          32'h04: dec.sel = SEL_MODE;
          32'h0C: dec.sel = SEL_EMODE2;
          32'h14: dec.sel = cs ? SEL_TIMA : SEL_ZERO;
          32'h18: dec.sel = cs ? SEL_TIMB : SEL_ZERO;
          32'h1C: dec.sel = cs ? SEL_NONE : SEL_TIMA;
          32'h20: dec.sel = cs ? SEL_NONE : SEL_TIMB;
          32'h24: dec.sel = SEL_RFR;
          32'h28: dec.sel = SEL_MANUAL;
          default: dec.sel = SEL_NONE;
        endcase
        if (dec.sel == SEL_NONE) begin
          dec.rd_err = 1'b1;
          dec.wr_err = 1'b1;
        end
      end else begin
        case (a32)
          32'h00: dec = '{sel: SEL_REV,     cs: 1'b0, rd_err: 1'b0, wr_err: 1'b1};
          32'h10: dec = '{sel: SEL_SYSCFG,  cs: 1'b0, rd_err: 1'b0, wr_err: 1'b0};
          32'h14: dec = '{sel: SEL_STATUS,  cs: 1'b0, rd_err: 1'b0, wr_err: 1'b1};
          32'h40: dec = '{sel: SEL_CSCFG,   cs: 1'b0, rd_err: 1'b0, wr_err: 1'b0};
          32'h44: dec = '{sel: SEL_SHARE,   cs: 1'b0, rd_err: 1'b0, wr_err: 1'b0};
          32'h48: dec = '{sel: SEL_ZERO,    cs: 1'b0, rd_err: 1'b0, wr_err: 1'b1};
          32'h4C: dec = '{sel: SEL_ZERO,    cs: 1'b0, rd_err: 1'b0, wr_err: 1'b1};
          32'h60: dec = '{sel: SEL_DLLA,    cs: 1'b0, rd_err: 1'b0, wr_err: 1'b0};
          32'h64: dec = '{sel: SEL_DLLA_ST, cs: 1'b0, rd_err: 1'b0, wr_err: 1'b1};
          32'h68: dec = '{sel: SEL_ZERO,    cs: 1'b0, rd_err: 1'b0, wr_err: 1'b0};
          32'h6C: dec = '{sel: SEL_ZERO,    cs: 1'b0, rd_err: 1'b0, wr_err: 1'b1};
          32'h70: dec = '{sel: SEL_POWER,   cs: 1'b0, rd_err: 1'b0, wr_err: 1'b0};
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_cfg_global.sv
module sdram_cfg_global
  import sdram_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] REVISION = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  regsel_e           sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd
);

  logic [DATA_W-1:0] syscfg_q;
  logic [DATA_W-1:0] cscfg_q;
  logic [DATA_W-1:0] share_q;
  logic [DATA_W-1:0] dlla_q;
  logic [DATA_W-1:0] power_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      syscfg_q <= '0;
      cscfg_q  <= '0;
      share_q  <= '0;
      dlla_q   <= '0;
      power_q  <= RST_POWER;
    end else if (wr) begin
      case (sel)
        SEL_SYSCFG: syscfg_q <= wdata & M_SYSCFG;
        SEL_CSCFG:  cscfg_q  <= wdata & M_CSCFG;
        SEL_SHARE:  if (!share_q[LOCK_BIT]) share_q <= wdata & M_SHARE;
        SEL_DLLA:   dlla_q   <= wdata & M_DLLA;
        SEL_POWER:  power_q  <= wdata & M_POWER;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_REV:     rd = REVISION;
      SEL_STATUS:  rd = 32'h1;
      SEL_SYSCFG:  rd = syscfg_q;
      SEL_CSCFG:   rd = cscfg_q;
      SEL_SHARE:   rd = share_q;
      SEL_DLLA:    rd = dlla_q;
      SEL_DLLA_ST: rd = ~(dlla_q & (32'h1 << DLL_PROBE));
      SEL_POWER:   rd = power_q;
      default:     rd = '0;
    endcase
  end

endmodule

// File: rtl/sdram_cfg_csbank.sv
module sdram_cfg_csbank
  import sdram_cfg_pkg::*;
#(
  parameter logic BANK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  regsel_e           sel,
  input  logic              cs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd
);

  logic [DATA_W-1:0] mcfg_q;
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] emode2_q;
  logic [DATA_W-1:0] tima_q;
  logic [DATA_W-1:0] timb_q;
  logic [DATA_W-1:0] rfr_q;
  logic [DATA_W-1:0] manual_q;
  logic              hit;
  logic [DATA_W-1:0] mcfg_mask;

  assign hit       = (cs == BANK);
  assign mcfg_mask = wdata[MUXSEL_BIT] ? M_MCFG_LG : M_MCFG_NM;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcfg_q   <= '0;
      mode_q   <= RST_MODE;
      emode2_q <= '0;
      tima_q   <= '0;
      timb_q   <= '0;
      rfr_q    <= '0;
      manual_q <= '0;
    end else if (wr && hit) begin
      case (sel)
        SEL_MCFG:   if (!mcfg_q[LOCK_BIT]) mcfg_q <= wdata & mcfg_mask;
        SEL_MODE:   mode_q   <= wdata & M_MODE;
        SEL_EMODE2: emode2_q <= wdata & M_MODE;
        SEL_TIMA:   tima_q   <= wdata & M_TIMA;
        SEL_TIMB:   timb_q   <= wdata & M_TIMB;
        SEL_RFR:    rfr_q    <= wdata & M_RFR;
        SEL_MANUAL: manual_q <= wdata & M_MANUAL;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd = '0;
    if (hit) begin
      case (sel)
        SEL_MCFG:   rd = mcfg_q;
        SEL_MODE:   rd = mode_q;
        SEL_EMODE2: rd = emode2_q;
        SEL_TIMA:   rd = tima_q;
        SEL_TIMB:   rd = timb_q;
        SEL_RFR:    rd = rfr_q;
        SEL_MANUAL: rd = manual_q;
        default:    rd = '0;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [DATA_W-1:0] REVISION  = 32'h0000_0040,
  parameter int unsigned       CS_BASE   = 32'h80,
  parameter int unsigned       CS_STRIDE = 32'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              err_pulse,
  output logic [ADDR_W-1:0] err_addr
);

  dec_t              dec;
  logic              size_ok;
  logic              wr_fire;
  logic              bad;
  logic [DATA_W-1:0] glob_rd;
  logic [DATA_W-1:0] bank_rd [NCS];
  logic [DATA_W-1:0] mux_rd;

  sdram_cfg_decode #(
    .ADDR_W   (ADDR_W),
    .CS_BASE  (CS_BASE),
    .CS_STRIDE(CS_STRIDE)
  ) u_dec (
    .addr(acc_addr),
    .dec (dec)
  );

  assign size_ok = (acc_size == SZ_WORD);
  assign wr_fire = acc_valid && acc_we && size_ok && !dec.wr_err;
  assign bad     = !size_ok || (acc_we ? dec.wr_err : dec.rd_err);

  sdram_cfg_global #(
    .REVISION(REVISION)
  ) u_glob (
    .clk  (clk),
    .rst  (rst),
    .wr   (wr_fire),
    .sel  (dec.sel),
    .wdata(acc_wdata),
    .rd   (glob_rd)
  );

  for (genvar b = 0; b < NCS; b++) begin : g_bank
    sdram_cfg_csbank #(
      .BANK(1'(b))
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .wr   (wr_fire),
      .sel  (dec.sel),
      .cs   (dec.cs),
      .wdata(acc_wdata),
      .rd   (bank_rd[b])
    );
  end

  always_comb begin
    mux_rd = glob_rd;
    for (int b = 0; b < NCS; b++) mux_rd = mux_rd | bank_rd[b];
  end

  assign acc_rdata = (size_ok && !dec.rd_err) ? mux_rd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_addr  <= '0;
    end else begin
      err_pulse <= acc_valid && bad;
      if (acc_valid && bad) err_addr <= acc_addr;
    end
  end

endmodule

// File: rtl/sdram_cfg_regs_chk.sv
module sdram_cfg_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic [31:0]       acc_rdata,
  input logic              err_pulse,
  input logic [ADDR_W-1:0] err_addr
);

  logic word;
  logic share_rd;
  assign word     = (acc_size == 2'd2);
  assign share_rd = acc_valid && !acc_we && word && (acc_addr == ADDR_W'(8'h44));

  a_r2_badwidth_zero: assert property (@(posedge clk) disable iff (rst)
    !word |-> acc_rdata == 32'h0);

  a_r2_badwidth_err: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !word) |=> err_pulse);

  a_r3_status_one: assert property (@(posedge clk) disable iff (rst)
    (word && acc_addr == ADDR_W'(8'h14)) |-> acc_rdata == 32'h1);

  a_r6_dll_status: assert property (@(posedge clk) disable iff (rst)
    (word && acc_addr == ADDR_W'(8'h64)) |-> (acc_rdata | 32'h4) == 32'hFFFF_FFFF);

  a_r6_dllb_zero: assert property (@(posedge clk) disable iff (rst)
    (word && (acc_addr == ADDR_W'(8'h68) || acc_addr == ADDR_W'(8'h6C))) |-> acc_rdata == 32'h0);

  a_r5_share_frozen: assert property (@(posedge clk) disable iff (rst)
    (share_rd && $past(share_rd) && $past(acc_rdata[30])) |-> $stable(acc_rdata));

  a_r11_misaligned_err: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr[1:0] != 2'b00) |=> (err_pulse && err_addr == $past(acc_addr)));

  a_r12_err_cause: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(acc_valid));

endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_valid(acc_valid),
  .acc_we   (acc_we),
  .acc_addr (acc_addr),
  .acc_size (acc_size),
  .acc_rdata(acc_rdata),
  .err_pulse(err_pulse),
  .err_addr (err_addr)
);

// File: tb/sim_sdram_cfg_regs.sv
module sim_sdram_cfg_regs;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] REV        = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_we = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [1:0]  acc_size = 2'd2;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        err_pulse;
  logic [7:0]  err_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cfg_regs u0 (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata),
    .err_pulse(err_pulse),
    .err_addr (err_addr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic bit rd_bad(input int a);
    case (a)
      'h00, 'h10, 'h14, 'h40, 'h44, 'h48, 'h4C, 'h60, 'h64, 'h68, 'h6C, 'h70,
      'h80, 'h84, 'h8C, 'h94, 'h98, 'h9C, 'hA0, 'hA4, 'hA8,
      'hB0, 'hB4, 'hBC, 'hC4, 'hC8, 'hD4, 'hD8: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit wr_bad(input int a);
    case (a)
      'h00, 'h14, 'h48, 'h4C, 'h64, 'h6C: return 1'b1;
      default: return rd_bad(a);
    endcase
  endfunction

  function automatic logic [31:0] wmask(input int a, input logic [31:0] d);
    case (a)
      'h10: return 32'h0000_0018;
      'h40: return 32'h0000_030F;
      'h44: return 32'h4000_7F00;
      'h60: return 32'hFFFF_00FE;
      'h70: return 32'h04FF_FFFD;
      'h80, 'hB0: return d[19] ? 32'h477B_FFDF : 32'h41FB_FFDF;
      'h84, 'h8C, 'hB4, 'hBC: return 32'h0000_0FFF;
      'hA4, 'hD4: return 32'h00FF_FF03;
      'hA8, 'hD8: return 32'hFFFF_000F;
      'h9C, 'hC4: return 32'hFFFF_FFDF;
      'hA0, 'hC8: return 32'h0003_77FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(input int a);
    case (a)
      'h00, 'h14, 'h48, 'h4C, 'h6C: return "R3";
      'h10, 'h40, 'h60, 'h70: return "R4";
      'h44: return "R5";
      'h64, 'h68: return "R6";
      'h80, 'hB0: return "R8";
      'h84, 'h8C, 'hB4, 'hBC, 'hA4, 'hD4, 'hA8, 'hD8: return "R9";
      'h9C, 'hA0, 'hC4, 'hC8, 'h94, 'h98: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    if (rd_bad(a)) return 32'h0;
    case (a)
      'h00: return REV;
      'h14: return 32'h1;
      'h64: return ~(mdl['h60 >> 2] & 32'h4);
      default: return mdl[a >> 2];
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    mdl['h70 >> 2] = 32'h85;
    mdl['h84 >> 2] = 32'h24;
    mdl['hB4 >> 2] = 32'h24;
  endtask

  task automatic model_write(input int a, input logic [31:0] d);
    logic [31:0] m;
    m = wmask(a, d);
    if (wr_bad(a) || m == 32'h0) return;
    if ((a == 'h44 || a == 'h80 || a == 'hB0) && mdl[a >> 2][30]) return;
    mdl[a >> 2] = d & m;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic access(input logic [7:0] a, input logic we, input logic [31:0] d,
                        input logic [1:0] sz, output logic [31:0] rd, output logic e,
                        output logic [7:0] ea);
    acc_valid = 1'b1;
    acc_we    = we;
    acc_addr  = a;
    acc_wdata = d;
    acc_size  = sz;
    #1 rd = acc_rdata;
    @(negedge clk);
    e  = err_pulse;
    ea = err_addr;
    acc_valid = 1'b0;
    acc_we    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic write_sweep(input logic [31:0] d);
    logic [31:0] rd;
    logic e;
    logic [7:0] ea;
    for (int a = 0; a < 256; a += 4) begin
      access(8'(a), 1'b1, d, 2'd2, rd, e, ea);
      chk(wr_bad(a) ? tag(a) : "R12", $sformatf("write err @%02h", a), 32'(e), 32'(wr_bad(a)));
      if (wr_bad(a)) chk("R11", $sformatf("err_addr @%02h", a), 32'(ea), 32'(a));
      model_write(a, d);
    end
  endtask

  task automatic read_sweep(input string req_all);
    logic [31:0] rd;
    logic e;
    logic [7:0] ea;
    for (int a = 0; a < 256; a += 4) begin
      access(8'(a), 1'b0, 32'h0, 2'd2, rd, e, ea);
      chk(req_all == "" ? tag(a) : req_all, $sformatf("read @%02h", a), rd, exp_rd(a));
      chk(rd_bad(a) ? "R11" : "R12", $sformatf("read err @%02h", a), 32'(e), 32'(rd_bad(a)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic e;
    logic [7:0] ea;

    do_reset();
    chk("R1", "err after reset", 32'(err_pulse), 32'h0);
    read_sweep("R1");

    write_sweep(32'h1234_5678);
    read_sweep("");

    write_sweep(32'hFFFF_FFFF);   // sets both locks, bit 19 mask variant
    read_sweep("");

    write_sweep(32'h5A5A_A5A5);   // locked registers must hold
    read_sweep("");
    access(8'h44, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R5", "sharing frozen", rd, 32'h4000_7F00);
    access(8'h80, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R8", "mcfg0 frozen", rd, 32'h477B_FFDF);

    do_reset();
    access(8'h80, 1'b1, 32'hFFF7_FFFF, 2'd2, rd, e, ea);
    access(8'h80, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R8", "mcfg0 bit19 clear mask", rd, 32'hFFF7_FFFF & 32'h41FB_FFDF);
    access(8'h44, 1'b1, 32'h0000_7F00, 2'd2, rd, e, ea);
    access(8'h44, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R5", "sharing writable after reset", rd, 32'h0000_7F00);

    // R7 independent banks
    access(8'h84, 1'b1, 32'h0000_0111, 2'd2, rd, e, ea);
    access(8'hB4, 1'b1, 32'h0000_0222, 2'd2, rd, e, ea);
    access(8'h84, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R7", "cs0 mode", rd, 32'h111);
    access(8'hB4, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R7", "cs1 mode", rd, 32'h222);

    // R10 overlay: cs1 timing does not reach cs0 delay-line slot
    access(8'hC4, 1'b1, 32'hFFFF_FFFF, 2'd2, rd, e, ea);
    access(8'h94, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R10", "delay-line slot stays zero", rd, 32'h0);
    access(8'h9C, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R10", "cs0 timing A untouched", rd, 32'h0);

    // R2 bad widths
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      access(8'h70, 1'b1, 32'h0, 2'(s), rd, e, ea);
      chk("R2", $sformatf("bad width write err size %0d", s), 32'(e), 32'h1);
      access(8'h70, 1'b0, 0, 2'(s), rd, e, ea);
      chk("R2", $sformatf("bad width read data size %0d", s), rd, 32'h0);
      chk("R2", $sformatf("bad width read err size %0d", s), 32'(e), 32'h1);
      access(8'h70, 1'b0, 0, 2'd2, rd, e, ea);
      chk("R2", "power unchanged", rd, 32'h85);
    end

    // R11 misaligned and bank-1 holes
    access(8'h81, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R11", "misaligned data", rd, 32'h0);
    chk("R11", "misaligned err", 32'(e), 32'h1);
    chk("R11", "misaligned err_addr", 32'(ea), 32'h81);
    access(8'hCC, 1'b1, 32'hFFFF_FFFF, 2'd2, rd, e, ea);
    chk("R11", "bank1 hole err_addr", 32'(ea), 32'hCC);
    access(8'h9C, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R11", "hole write did not reach cs0", rd, 32'h0);

    // R12 strobe lasts one cycle
    @(negedge clk);
    chk("R12", "strobe low when idle", 32'(err_pulse), 32'h0);

    // R6 DLL status both ways
    access(8'h60, 1'b1, 32'h0000_0004, 2'd2, rd, e, ea);
    access(8'h64, 1'b0, 0, 2'd2, rd, e, ea);
    chk("R6", "dll status probe set", rd, 32'hFFFF_FFFB);
    access(8'h68, 1'b1, 32'hFFFF_FFFF, 2'd2, rd, e, ea);
    chk("R6", "dllb write silent", 32'(e), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule